// File: doc/BRIEF.md
# Finite-Count Burst PWM Channel

A single pulse-width-modulation channel with a small word-addressed register port. Software programs a period, a duty value and a control word, then sets the enable bit. In continuous mode the channel repeats its period for as long as the enable bit stays set. In one-shot mode it emits a programmed number of periods, from 1 to 256, and then stops by itself. At that point it drops the output, clears its own enable bit and sets a completion status bit. That status bit reaches the interrupt line only when the interrupt-enable bit is set.

The period counter advances on cycles where `tick_en` is high. In continuous mode it advances on every such tick. In one-shot mode it advances on every second tick. Period and duty are written into shadow registers and reach the running counter only at a period boundary, so a period in progress is never cut short.

Control is a three-state machine. `ST_IDLE` moves to `ST_CONT` or to `ST_BURST` when the enable bit is seen set, and the one-shot bit picks which of the two. `ST_CONT` returns to `ST_IDLE` when the enable bit is cleared. `ST_BURST` returns to `ST_IDLE` when the enable bit is cleared or on the wrap at the end of the last period of the burst.

Top module: `burst_pwm_channel`

## Requirements
- R1: After reset the output is low, the interrupt line is low, and every register reads 0. The word addresses are: 0 control, 1 period, 2 duty, 3 count (read only), 4 status, 5 interrupt enable.
- R2: While the channel runs, the output is high when the count is below the active duty value and low otherwise. A duty value of 0 keeps the output low. A duty value at or above the period keeps the output high for the whole period.
- R3: Continuous mode is selected by control bit 1 = 0 together with enable bit 0 = 1. In this mode the count rises by one on each cycle with `tick_en` high and wraps to 0 after `period` counts.
- R4: One-shot mode is selected by control bit 1 = 1. The count advances once per two enabled ticks. Control bits 31:24 hold N-1, giving a burst of N periods with N from 1 to 256. After N periods the output stays low and hardware clears enable bit 0.
- R5: Status register bit 0 is set when a burst completes. `irq_out` equals that bit ANDed with bit 0 of the interrupt-enable register.
- R6: Writing 1 to status bit 0 clears it. Writing 0 to it has no effect.
- R7: Period and duty writes made during a period take effect at the next period boundary.
- R8: The count register returns the current value of the period counter.
- R9: When software clears the enable bit, the output is low and the count reads 0 from the second cycle after the write.
- R10: While `tick_en` is low, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable for the period counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pwm_out | output | 1 | PWM output |
| irq_out | output | 1 | Burst-complete interrupt, masked |

## Verification
The bench times each burst from the enable write to the interrupt. The cases include the full 256-period burst with a one-count period, where a field decoded as N instead of N-1, or a divider that is skipped, would shift the interrupt by whole periods. Duty values of zero and above the period check the compare at both ends. A clamp that is missing, or a compare written as "not above", would add or drop high cycles. A duty write made in the middle of a period must leave that period unchanged, and a channel that loads shadows at once would fail here. Finally, the bench clears an interrupt with the status bit set while it is masked, writes 0 to the status bit, and freezes the count with the tick input. This exposes a status bit that is lost under the mask, cleared by the wrong data value, or a counter that runs on without ticks.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_PERIOD = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_DUTY   = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_COUNT  = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_IRQEN  = 3'd5;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_OS_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONT  = 2'd1,
        ST_BURST = 2'd2
    } chan_state_t;

endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs
    import burst_pwm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 burst_done,
    output logic                 run_en,
    output logic                 one_shot,
    output logic [BURST_W-1:0]   burst_len,
    output logic [CNT_W-1:0]     per_shadow,
    output logic [CNT_W-1:0]     duty_shadow,
    output logic                 irq_en
);

    localparam int BURST_LSB = DATA_W - BURST_W;

    logic wr_ctrl, wr_per, wr_duty, wr_ie;
    logic unused_wdata;

    assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_per  = reg_we && (reg_addr == ADDR_PERIOD);
    assign wr_duty = reg_we && (reg_addr == ADDR_DUTY);
    assign wr_ie   = reg_we && (reg_addr == ADDR_IRQEN);
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en      <= 1'b0;
            one_shot    <= 1'b0;
            burst_len   <= '0;
            per_shadow  <= '0;
            duty_shadow <= '0;
            irq_en      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run_en    <= reg_wdata[CTRL_EN_BIT];
                one_shot  <= reg_wdata[CTRL_OS_BIT];
                burst_len <= reg_wdata[BURST_LSB +: BURST_W];
            end else if (burst_done) begin
                run_en <= 1'b0;
            end
            if (wr_per)  per_shadow  <= reg_wdata[CNT_W-1:0];
            if (wr_duty) duty_shadow <= reg_wdata[CNT_W-1:0];
            if (wr_ie)   irq_en      <= reg_wdata[0];
        end
    end

endmodule

// File: rtl/bpwm_tick_div.sv
module bpwm_tick_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic div_sel,
    input  logic clear,
    output logic step
);

    generate
        if (DIV <= 1) begin : g_nodiv
            logic unused_ctl;
            assign unused_ctl = clk ^ rst_n ^ div_sel ^ clear;
            assign step = tick_en;
        end else begin : g_div
            localparam int PH_W = $clog2(DIV);
            localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
            logic [PH_W-1:0] ph_q;

            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    ph_q <= '0;
                end else if (tick_en && div_sel) begin
                    ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
                end
            end

            assign step = tick_en && (!div_sel || (ph_q == PH_LAST));
        end
    endgenerate

endmodule

// File: rtl/bpwm_core.sv
module bpwm_core
    import burst_pwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               one_shot,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [CNT_W-1:0]   per_shadow,
    input  logic [CNT_W-1:0]   duty_shadow,
    input  logic               step,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CNT_W-1:0]   per_act_o,
    output logic               busy_o,
    output logic               div_sel_o,
    output logic               burst_done_o,
    output logic               pwm_o
);

    chan_state_t        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, per_act_q, duty_act_q;
    logic [BURST_W-1:0] left_q;
    logic               running, last, wrap;

    assign running = (state_q != ST_IDLE);
    assign last    = (per_act_q == '0) || (cnt_q >= per_act_q - 1'b1);
    assign wrap    = running && run_en && step && last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_en) state_d = one_shot ? ST_BURST : ST_CONT;
            ST_CONT:  if (!run_en) state_d = ST_IDLE;
            ST_BURST: if (!run_en || (wrap && left_q == '0)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // counter, active compare values and remaining-period count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            per_act_q  <= '0;
            duty_act_q <= '0;
            left_q     <= '0;
        end else if (state_q == ST_IDLE) begin
            cnt_q <= '0;
            if (run_en) begin
                per_act_q  <= per_shadow;
                duty_act_q <= duty_shadow;
                left_q     <= burst_len;
            end
        end else if (!run_en) begin
            cnt_q <= '0;
        end else if (step) begin
            if (last) begin
                cnt_q      <= '0;
                per_act_q  <= per_shadow;
                duty_act_q <= duty_shadow;
                if (state_q == ST_BURST && left_q != '0) left_q <= left_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cnt_o        = cnt_q;
        per_act_o    = per_act_q;
        busy_o       = running;
        div_sel_o    = (state_q == ST_BURST);
        burst_done_o = (state_q == ST_BURST) && wrap && (left_q == '0);
        pwm_o        = running && (cnt_q < duty_act_q);
    end

endmodule

// File: rtl/bpwm_irq.sv
module bpwm_irq
    import burst_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              clr_bit,
    input  logic              burst_done,
    input  logic              irq_en,
    output logic              sts_o,
    output logic              irq_o
);

    logic sts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (burst_done) begin
            sts_q <= 1'b1;
        end else if (reg_we && reg_addr == ADDR_STATUS && clr_bit) begin
            sts_q <= 1'b0;
        end
    end

    assign sts_o = sts_q;
    assign irq_o = sts_q && irq_en;

endmodule

// File: rtl/burst_pwm_channel.sv
module burst_pwm_channel
    import burst_pwm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int BURST_W  = 8,
    parameter int SHOT_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out,
    output logic              irq_out
);

    localparam int BURST_LSB = DATA_W - BURST_W;

    logic               run_en, one_shot, irq_en, sts;
    logic [BURST_W-1:0] burst_len;
    logic [CNT_W-1:0]   per_shadow, duty_shadow, cnt, per_act;
    logic               step, busy, div_sel, burst_done;

    bpwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BURST_W(BURST_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .burst_done(burst_done), .run_en(run_en),
        .one_shot(one_shot), .burst_len(burst_len), .per_shadow(per_shadow),
        .duty_shadow(duty_shadow), .irq_en(irq_en)
    );

    bpwm_tick_div #(.DIV(SHOT_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_sel(div_sel),
        .clear(!busy), .step(step)
    );

    bpwm_core #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .one_shot(one_shot),
        .burst_len(burst_len), .per_shadow(per_shadow), .duty_shadow(duty_shadow),
        .step(step), .cnt_o(cnt), .per_act_o(per_act), .busy_o(busy),
        .div_sel_o(div_sel), .burst_done_o(burst_done), .pwm_o(pwm_out)
    );

    bpwm_irq u_irq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .clr_bit(reg_wdata[0]), .burst_done(burst_done), .irq_en(irq_en),
        .sts_o(sts), .irq_o(irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN_BIT]              = run_en;
                reg_rdata[CTRL_OS_BIT]              = one_shot;
                reg_rdata[BURST_LSB +: BURST_W]     = burst_len;
            end
            ADDR_PERIOD: reg_rdata[CNT_W-1:0] = per_shadow;
            ADDR_DUTY:   reg_rdata[CNT_W-1:0] = duty_shadow;
            ADDR_COUNT:  reg_rdata[CNT_W-1:0] = cnt;
            ADDR_STATUS: reg_rdata[0]         = sts;
            ADDR_IRQEN:  reg_rdata[0]         = irq_en;
            default:     reg_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker
    import burst_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wbit0,
    input logic              run_en,
    input logic              burst_done,
    input logic              sts,
    input logic              busy,
    input logic              pwm,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  per_act
);

    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && per_act != '0) |-> (cnt < per_act));

    assert_enable_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !(reg_we && reg_addr == ADDR_CTRL)) |=> !run_en);

    assert_status_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(burst_done));

    assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts) |-> $past(reg_we && reg_addr == ADDR_STATUS && wbit0));

    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_en) |=> !pwm);

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && run_en && busy) |=> $stable(cnt));

endmodule

bind burst_pwm_channel bpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .wbit0(reg_wdata[0]), .run_en(run_en),
    .burst_done(burst_done), .sts(sts), .busy(busy), .pwm(pwm_out),
    .cnt(cnt), .per_act(per_act)
);

// File: tb/sim_burst_pwm_channel.sv
module sim_burst_pwm_channel;
    import burst_pwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        pwm_out, irq_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_pwm_channel u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        os;
        logic [15:0] per;
        logic [15:0] duty;
        logic [7:0]  blen;
        logic [15:0] cyc;
        logic [15:0] hi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd4, 16'd1, 8'd0,   16'd9,   16'd2},
        '{1'b1, 16'd5, 16'd2, 8'd2,   16'd31,  16'd12},
        '{1'b1, 16'd3, 16'd3, 8'd1,   16'd13,  16'd12},
        '{1'b1, 16'd4, 16'd0, 8'd1,   16'd17,  16'd0},
        '{1'b1, 16'd2, 16'd5, 8'd0,   16'd5,   16'd4},
        '{1'b1, 16'd1, 16'd1, 8'd255, 16'd513, 16'd512},
        '{1'b0, 16'd4, 16'd1, 8'd0,   16'd12,  16'd3},
        '{1'b0, 16'd6, 16'd4, 8'd0,   16'd18,  16'd12}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d, c1;
        int n, hi;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        check(pwm_out == 1'b0, "R1 pwm after reset", pwm_out, 0);
        check(irq_out == 1'b0, "R1 irq after reset", irq_out, 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check(d == 32'd0, "R1 register after reset", d, 0);
        end

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            wr(ADDR_PERIOD, {16'd0, VECS[v].per});
            wr(ADDR_DUTY, {16'd0, VECS[v].duty});
            wr(ADDR_IRQEN, 32'd1);
            wr(ADDR_CTRL, {VECS[v].blen, 22'd0, VECS[v].os, 1'b1});
            n = 0; hi = 0;
            if (VECS[v].os) begin
                do begin
                    @(posedge clk); #1;
                    n++; hi += int'(pwm_out);
                end while (!irq_out && n < 3000);
                check(n == int'(VECS[v].cyc), "R4 burst length in cycles", n, VECS[v].cyc);
                check(hi == int'(VECS[v].hi), "R2 high cycles in burst", hi, VECS[v].hi);
                check(pwm_out == 1'b0, "R4 output low after burst", pwm_out, 0);
                rd(ADDR_CTRL, d);
                check(d[0] == 1'b0, "R4 enable cleared by hardware", d[0], 0);
                rd(ADDR_STATUS, d);
                check(d[0] == 1'b1, "R5 status set at burst end", d[0], 1);
                wr(ADDR_STATUS, 32'd1);
                check(irq_out == 1'b0, "R6 status cleared by write 1", irq_out, 0);
            end else begin
                for (int i = 0; i < int'(VECS[v].cyc); i++) begin
                    @(posedge clk); #1;
                    hi += int'(pwm_out);
                end
                check(hi == int'(VECS[v].hi), "R3 continuous high cycles", hi, VECS[v].hi);
                check(irq_out == 1'b0, "R5 no interrupt in continuous mode", irq_out, 0);
                wr(ADDR_CTRL, 32'd0);
                @(posedge clk); #1;
                check(pwm_out == 1'b0, "R9 output low after disable", pwm_out, 0);
                rd(ADDR_COUNT, d);
                check(d == 32'd0, "R9 count zero after disable", d, 0);
            end
        end

        // R5/R6: masked interrupt
        wr(ADDR_IRQEN, 32'd0);
        wr(ADDR_PERIOD, 32'd2);
        wr(ADDR_DUTY, 32'd1);
        wr(ADDR_CTRL, 32'h0000_0003);
        repeat (10) @(posedge clk); #1;
        check(irq_out == 1'b0, "R5 interrupt masked", irq_out, 0);
        rd(ADDR_STATUS, d);
        check(d[0] == 1'b1, "R5 status set while masked", d[0], 1);
        rd(ADDR_COUNT, d);
        check(d == 32'd0 && pwm_out == 1'b0, "R4 stays stopped after burst", d, 0);
        wr(ADDR_STATUS, 32'd0);
        rd(ADDR_STATUS, d);
        check(d[0] == 1'b1, "R6 write 0 leaves status", d[0], 1);
        wr(ADDR_IRQEN, 32'd1);
        check(irq_out == 1'b1, "R5 unmask raises interrupt", irq_out, 1);
        wr(ADDR_STATUS, 32'd1);
        check(irq_out == 1'b0, "R6 clear drops interrupt", irq_out, 0);

        // R7/R8: duty write mid-period, count readback
        wr(ADDR_PERIOD, 32'd10);
        wr(ADDR_DUTY, 32'd2);
        wr(ADDR_CTRL, 32'h0000_0001);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (i == 7) check(reg_rdata == 32'd7, "R8 count readback", reg_rdata, 7);
            hi += int'(pwm_out);
            if (i == 3) begin reg_we = 1'b1; reg_addr = ADDR_DUTY; reg_wdata = 32'd6; end
            if (i == 4) begin reg_we = 1'b0; reg_addr = ADDR_COUNT; end
            if (i == 9) begin
                check(hi == 2, "R7 current period keeps old duty", hi, 2);
                hi = 0;
            end
        end
        check(hi == 6, "R7 new duty at next period", hi, 6);

        // R10: tick freeze
        rd(ADDR_COUNT, c1);
        tick_en = 1'b0;
        repeat (5) @(posedge clk); #1;
        rd(ADDR_COUNT, d);
        check(d == c1, "R10 count holds without ticks", d, c1);
        tick_en = 1'b1;
        wr(ADDR_CTRL, 32'd0);
        @(posedge clk); #1;
        check(pwm_out == 1'b0, "R9 output low after disable", pwm_out, 0);

        finish_run();
    end

endmodule